// File: doc/BRIEF.md
# Control-Register Bus Interface

This block connects one bus master to a set of register slaves over a dedicated control-register bus. A local client hands the master one command at a time: a read or a write of a 32-bit register at a 10-bit address. The master drives the address, the write data and either a read strobe or a write strobe onto the bus. It holds them steady until an acknowledge comes back, then reports a single response pulse carrying the read data or an error flag.

Each slave owns a power-of-two window of addresses at a configurable base. When it is addressed it updates or returns one word and raises its acknowledge. That acknowledge means "data valid" on a read and "write complete" on a write. Slave read outputs and acknowledges are merged by OR, so a slave that is not driving a response keeps its read output at zero. A slave may be paced by a periodic clock enable, which stands in for a slower clock with aligned rising edges. An address that no slave claims ends in a timeout after 64 cycles, and the master then frees the bus.

The default map has three slaves of four words each: slave 0 at 0x040-0x043 enabled every cycle, slave 1 at 0x080-0x083 enabled every 2nd cycle, and slave 2 at 0x0C0-0x0C3 enabled every 3rd cycle. The low two address bits select the word inside a slave.

Top module: `crb_subsys`

## Requirements
- R1: After reset, cmd_ready is 1, rsp_valid is 0, both bus strobes are 0, and every slave register reads as 0.
- R2: A write to a mapped address followed by a read of the same address returns all 32 written bits with rsp_err 0. A write response carries rsp_rdata equal to 0.
- R3: A write changes only the addressed word. Other words of the same slave and the same offset in other slaves keep their values.
- R4: A slave that is not acknowledging a read drives zero on its read output, so the OR-merged read data equals the addressed word exactly.
- R5: During a transaction exactly one strobe is high, matching the command type (bus_wr for a write, bus_rd for a read). The strobe and the address stay stable until acknowledge or timeout.
- R6: With a slave enabled every cycle, rsp_valid rises on the 2nd rising edge after the edge that accepts the command. cmd_ready is low for 4 cycles and is high again after the 4th edge.
- R7: With a slave enabled every D cycles, rsp_valid rises between the 2nd and the (D+1)th edge after acceptance.
- R8: A command to an unmapped address returns rsp_valid with rsp_err 1 and rsp_rdata 0 on the 64th edge after acceptance. An unmapped write changes no register.
- R9: While cmd_ready is 0, cmd_valid is ignored, and the command offered then has no effect on any register.
- R10: rsp_valid is a one-cycle pulse, issued once per accepted command.
- R11: After the strobe falls, a slave drops its acknowledge at its next enabled edge. The master does not accept a new command while the acknowledge is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered by the client |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 10 | Register address |
| cmd_wdata | input | 32 | Write data |
| cmd_ready | output | 1 | Master idle; a command is taken at the next edge |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response ended by timeout |
| rsp_rdata | output | 32 | Read data (0 for writes and timeouts) |
| bus_rd | output | 1 | Bus read strobe, brought out for observation |
| bus_wr | output | 1 | Bus write strobe, brought out for observation |
| bus_ack | output | 1 | OR-merged slave acknowledge, brought out for observation |

## Verification
For a slave enabled every cycle, the response is due on the 2nd edge after the accepting edge. For a slave enabled every D cycles it is due between the 2nd and the (D+1)th edge. An unmapped address answers on the 64th edge, and cmd_ready returns two edges after a fast response. The bench drives inputs at the falling edge and counts rising edges from the accepting edge. It samples rsp_valid at each following falling edge and compares the edge count with these figures, and it checks that the pulse is gone one cycle later. Register effects, including those of ignored or unmapped commands, are checked only by later reads through the same command port, against a model the bench keeps.

// File: rtl/crb_pkg.sv
// Shared types for the control-register bus: master sequencing states.
package crb_pkg;
    typedef enum logic [1:0] {
        M_IDLE = 2'd0,   // waiting for a client command
        M_REQ  = 2'd1,   // strobe on the bus, waiting for acknowledge
        M_REL  = 2'd2    // strobe removed, waiting for acknowledge to fall
    } mst_state_t;
endpackage

// File: rtl/crb_clk_en.sv
// Periodic clock-enable generator standing in for a slower, edge-aligned
// slave clock. Assumes DIV >= 1; DIV == 1 gives a permanently high enable.
module crb_clk_en #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic ce
);
    generate
        if (DIV <= 1) begin : g_full
            assign ce = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            // Free-running phase counter; the enable fires at phase zero.
            always_ff @(posedge clk) begin
                if (!rst_n)                       cnt <= '0;
                else if (cnt == CW'(DIV - 1))     cnt <= '0;
                else                              cnt <= cnt + 1'b1;
            end
            assign ce = (cnt == '0);
        end
    endgenerate
endmodule

// File: rtl/crb_master.sv
// Single bus master: takes one client command at a time, drives one strobe
// with address/data held stable until acknowledge or timeout, then waits for
// the acknowledge to fall before accepting the next command.
// Assumes at most one slave acknowledges any address.
module crb_master #(
    parameter int AW      = 10,
    parameter int DW      = 32,
    parameter int TIMEOUT = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_ready,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_rd,
    output logic          bus_wr,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata
);
    import crb_pkg::*;

    localparam int CW = $clog2(TIMEOUT + 1);

    mst_state_t    state;
    logic [CW-1:0] wait_cnt;

    assign cmd_ready = (state == M_IDLE);

    // Transaction sequencer: launch, wait for acknowledge or timeout, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= M_IDLE;
            wait_cnt  <= '0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_rd    <= 1'b0;
            bus_wr    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                M_IDLE: begin
                    if (cmd_valid) begin
                        bus_addr  <= cmd_addr;
                        bus_wdata <= cmd_wdata;
                        bus_wr    <= cmd_write;
                        bus_rd    <= !cmd_write;
                        wait_cnt  <= '0;
                        state     <= M_REQ;
                    end
                end
                M_REQ: begin
                    if (bus_ack) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b0;
                        rsp_rdata <= bus_wr ? '0 : bus_rdata;
                        bus_rd    <= 1'b0;
                        bus_wr    <= 1'b0;
                        state     <= M_REL;
                    end else if (wait_cnt == CW'(TIMEOUT - 1)) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b1;
                        rsp_rdata <= '0;
                        bus_rd    <= 1'b0;
                        bus_wr    <= 1'b0;
                        state     <= M_REL;
                    end else begin
                        wait_cnt  <= wait_cnt + 1'b1;
                    end
                end
                M_REL: begin
                    if (!bus_ack) state <= M_IDLE;
                end
                default: state <= M_IDLE;
            endcase
        end
    end

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    // R5
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && !bus_ack) |=>
        ((rsp_valid && rsp_err) || ((bus_rd || bus_wr) && $stable(bus_addr) && $stable(bus_wdata))));
    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R8
    tmo_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && !(bus_rd || bus_wr) && bus_ack) |=> !(bus_rd || bus_wr));
endmodule

// File: rtl/crb_slave.sv
// Generic register slave: claims WORDS words starting at BASE, acts only on
// its clock-enable edges, raises one acknowledge per strobe and drops it once
// the strobe is gone. Read output is zero unless a read acknowledge is held.
// Assumes WORDS is a power of two (>= 2) and BASE is aligned to WORDS.
module crb_slave #(
    parameter int            AW    = 10,
    parameter int            DW    = 32,
    parameter logic [AW-1:0] BASE  = '0,
    parameter int            WORDS = 4,
    parameter int            DIV   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    input  logic          bus_wr,
    output logic          sl_ack,
    output logic [DW-1:0] sl_rdata
);
    localparam int IW = $clog2(WORDS);

    logic          ce;
    logic          hit;
    logic          sel;
    logic [IW-1:0] idx;
    logic [DW-1:0] regs [WORDS];

    crb_clk_en #(.DIV(DIV)) u_ce (.clk(clk), .rst_n(rst_n), .ce(ce));

    // Address decode against this slave's aligned window.
    assign hit = (bus_addr[AW-1:IW] == BASE[AW-1:IW]);
    assign sel = hit && (bus_rd || bus_wr);
    assign idx = bus_addr[IW-1:0];

    // Register update, acknowledge and read-data handshake on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sl_ack   <= 1'b0;
            sl_rdata <= '0;
            for (int i = 0; i < WORDS; i++) regs[i] <= '0;
        end else if (ce) begin
            if (sel && !sl_ack) begin
                sl_ack <= 1'b1;
                if (bus_wr) regs[idx] <= bus_wdata;
                if (bus_rd) sl_rdata  <= regs[idx];
            end else if (!(bus_rd || bus_wr)) begin
                sl_ack   <= 1'b0;
                sl_rdata <= '0;
            end
        end
    end

    // R4
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sl_ack |-> (sl_rdata == '0));
    // R11
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_ack && ce && !(bus_rd || bus_wr)) |=> !sl_ack);
    // R3
    ack_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sl_ack) |-> $past(sel));
endmodule

// File: rtl/crb_subsys.sv
// Control-register bus subsystem: one master, N_SLV register slaves at
// BASE0 + i*STRIDE each paced by an enable every (i+1) cycles, and the
// OR-merge of slave acknowledges and read data back to the master.
// Assumes windows do not overlap (STRIDE >= SLV_WORDS).
module crb_subsys #(
    parameter int AW        = 10,
    parameter int DW        = 32,
    parameter int N_SLV     = 3,
    parameter int SLV_WORDS = 4,
    parameter int BASE0     = 'h040,
    parameter int STRIDE    = 'h040,
    parameter int TIMEOUT   = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_ready,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_ack
);
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic [N_SLV-1:0] ack_v;
    logic [DW-1:0]    rdata_v [N_SLV];

    crb_master #(.AW(AW), .DW(DW), .TIMEOUT(TIMEOUT)) u_master (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    generate
        for (genvar g = 0; g < N_SLV; g++) begin : g_slv
            localparam logic [AW-1:0] SB = AW'(BASE0 + g * STRIDE);
            crb_slave #(.AW(AW), .DW(DW), .BASE(SB), .WORDS(SLV_WORDS), .DIV(g + 1)) u_slv (
                .clk(clk), .rst_n(rst_n),
                .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                .bus_rd(bus_rd), .bus_wr(bus_wr),
                .sl_ack(ack_v[g]), .sl_rdata(rdata_v[g])
            );
        end
    endgenerate

    // OR-merge of all slave responses toward the master.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_SLV; i++) bus_rdata = bus_rdata | rdata_v[i];
        bus_ack = |ack_v;
    end

    // R3
    single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_v));
endmodule

// File: tb/crb_subsys_test.sv
module crb_subsys_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [9:0]  cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;
    logic        cmd_ready, rsp_valid, rsp_err, bus_rd, bus_wr, bus_ack;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] model [3][4];

    always #10 clk = ~clk;   // 50 MHz

    crb_subsys uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ack(bus_ack)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Map: slave s (0..2) claims 0x040*(s+1) .. +3, enable every s+1 cycles.
    function automatic bit mapped(input logic [9:0] a);
        return (a[9:8] == 2'b00) && (a[7:6] != 2'b00) && (a[5:2] == 4'd0);
    endfunction
    function automatic int slv_of(input logic [9:0] a);
        return int'(a[7:6]) - 1;
    endfunction

    // One transaction; returns response data, error and latency in edges.
    task automatic txn(input bit w, input logic [9:0] a, input logic [31:0] d,
                       input bit inject, output logic [31:0] rd, output bit er,
                       output int lat, output bit stb_ok);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (inject) begin
            cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 10'h043; cmd_wdata = 32'hDEAD_BEEF;
        end
        lat = 0;
        stb_ok = 1'b1;
        while (lat < 300) begin
            if (!((bus_wr == w) && (bus_rd == !w))) stb_ok = 1'b0;
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 1) cmd_valid = 1'b0;
            if (rsp_valid) break;
        end
        rd = rsp_rdata;
        er = rsp_err;
        if (w && mapped(a)) model[slv_of(a)][a[1:0]] = d;
    endtask

    task automatic check_txn(input bit w, input logic [9:0] a, input logic [31:0] d,
                             input bit inject, input string tag);
        logic [31:0] rd, exp;
        bit er, ok;
        int lat, lo, hi;
        if (!w && mapped(a)) exp = model[slv_of(a)][a[1:0]];
        else exp = 32'h0;
        if (mapped(a)) begin lo = 2; hi = slv_of(a) + 2; end
        else begin lo = 64; hi = 64; end
        txn(w, a, d, inject, rd, er, lat, ok);
        chk(ok, "R5", {tag, " strobe type/hold"}, {31'd0, ok}, 32'd1);
        chk(rd == exp, mapped(a) ? (w ? "R2" : "R4") : "R8", {tag, " data"}, rd, exp);
        chk(er == !mapped(a), mapped(a) ? "R2" : "R8", {tag, " err"}, {31'd0, er}, {31'd0, !mapped(a)});
        chk(lat >= lo && lat <= hi, mapped(a) ? "R7" : "R8", {tag, " latency"}, lat, hi);
        @(negedge clk);
        chk(!rsp_valid, "R10", {tag, " pulse width"}, {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        bit er, ok;
        int lat;
        void'($urandom(32'd20250));
        for (int s = 0; s < 3; s++) for (int o = 0; o < 4; o++) model[s][o] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "ready after reset", {31'd0, cmd_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        chk(!bus_rd && !bus_wr, "R1", "strobes in reset", {30'd0, bus_rd, bus_wr}, 32'd0);
        rst_n = 1'b1;

        // R1 registers zero after reset
        check_txn(1'b0, 10'h0C2, 32'h0, 1'b0, "R1 reset read");

        // R6 fast slave timing
        txn(1'b1, 10'h041, 32'hA5A5_0F0F, 1'b0, rd, er, lat, ok);
        chk(lat == 2, "R6", "fast latency", lat, 32'd2);
        chk(rd == 32'h0, "R2", "write rsp data", rd, 32'h0);
        @(negedge clk);
        chk(!cmd_ready, "R6", "busy 3rd cycle", {31'd0, cmd_ready}, 32'd0);
        @(negedge clk);
        chk(cmd_ready, "R11", "ready after ack falls", {31'd0, cmd_ready}, 32'd1);

        // R2 readback, R3 isolation
        check_txn(1'b0, 10'h041, 32'h0, 1'b0, "R2 readback");
        check_txn(1'b1, 10'h081, 32'h1234_5678, 1'b0, "R3 write s1");
        check_txn(1'b0, 10'h041, 32'h0, 1'b0, "R3 s0 kept");
        check_txn(1'b0, 10'h0C1, 32'h0, 1'b0, "R3 s2 kept");
        check_txn(1'b0, 10'h040, 32'h0, 1'b0, "R3 neighbour kept");

        // R7 slow slave
        check_txn(1'b1, 10'h0C3, 32'hFFFF_FFFF, 1'b0, "R7 slow write");
        check_txn(1'b0, 10'h0C3, 32'h0, 1'b0, "R7 slow read");

        // R8 unmapped
        check_txn(1'b0, 10'h044, 32'h0, 1'b0, "R8 unmapped read");
        check_txn(1'b1, 10'h000, 32'h5555_5555, 1'b0, "R8 unmapped write");

        // R9 command offered while busy is ignored
        check_txn(1'b1, 10'h042, 32'h0BAD_F00D, 1'b1, "R9 busy inject");
        check_txn(1'b0, 10'h043, 32'h0, 1'b0, "R9 inject had no effect");

        // Random mix
        for (int i = 0; i < 120; i++) begin
            logic [9:0] a;
            bit w;
            w = 1'($urandom % 2);
            if ($urandom % 16 == 0) a = 10'h100 + 10'($urandom % 64);
            else a = 10'((($urandom % 3) + 1) * 'h40 + ($urandom % 4));
            check_txn(w, a, $urandom, 1'b0, "random");
        end

        // Final sweep: every register matches the model (R3, R8)
        for (int s = 0; s < 3; s++)
            for (int o = 0; o < 4; o++)
                check_txn(1'b0, 10'((s + 1) * 'h40 + o), 32'h0, 1'b0, "R3 final sweep");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule